// File: doc/BRIEF.md
# Static Memory Access Sequencer with External Wait

This block runs single read or write accesses to one external static memory bank for an internal bus master. The master raises a request with an address, a direction bit, write data and a wait-state count. The sequencer latches these values and pulls the active-low chip select. It also drives the address and, depending on the direction, either the active-low output enable or the active-low write enable together with the write data. The access phase is held for the programmed number of wait states. The cycle in which chip select first goes low counts as the first of these.

A slow device can stretch the access through an active-low wait input. The sequencer samples that input at the end of every access-phase cycle. The access phase ends at the first cycle that is both at or past the programmed count and has the wait input high, so the later of the two limits wins. A fixed three-cycle tail follows. Read data is captured on the last tail cycle. A one-cycle acknowledge marks the cycle in which chip select returns high. A new request is taken only after the sequencer has passed back through idle.

Top module: `static_mem_seq`

## Requirements
- R1: After reset, mem_cs_no, mem_oe_no and mem_we_no are 1, while ack_o and mem_wdata_oe_o are 0.
- R2: A request sampled high in idle makes mem_cs_no go low in the next cycle, with mem_addr_o equal to the latched address. For a read (we_i=0), mem_oe_no is low and mem_we_no is high. For a write (we_i=1), mem_oe_no is high.
- R3: With mem_wait_ni held high, chip select stays low for exactly N+3 cycles, where N is the wait-state count wait_cfg_i in the range 2 to 31.
- R4: A wait_cfg_i value of 0 or 1 is treated as 2, giving a chip-select low time of 5 cycles.
- R5: Access-phase cycles are numbered k=1,2,… from the first chip-select cycle, and mem_wait_ni is sampled at the end of each one. The access phase ends after the first cycle k≥N in which the sampled value is 1. Chip select is low for that k plus 3 cycles.
- R6: mem_wait_ni low only in cycles k<N has no effect on the access length.
- R7: For a read, rdata_o holds the value of mem_rdata_i in the last chip-select-low cycle. ack_o is 1 in exactly the first cycle after chip select goes high.
- R8: For a write, mem_wdata_oe_o is 1 and mem_wdata_o equals the latched write data in every chip-select-low cycle. mem_we_no is low in every chip-select-low cycle except the last one.
- R9: ack_o lasts one cycle. With req_i held high, chip select stays high for exactly 2 cycles between two accesses.
- R10: Changes on addr_i, wdata_i, we_i and wait_cfg_i after acceptance do not affect the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request from the host |
| we_i | input | 1 | Direction: 1 write, 0 read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| wait_cfg_i | input | CFG_W | Programmed wait-state count |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| mem_cs_no | output | 1 | External chip select, active low |
| mem_oe_no | output | 1 | External output enable, active low |
| mem_we_no | output | 1 | External write enable, active low |
| mem_addr_o | output | AW | External address |
| mem_wdata_o | output | DW | External write data |
| mem_wdata_oe_o | output | 1 | Drive enable for the external data bus |
| mem_rdata_i | input | DW | External read data |
| mem_wait_ni | input | 1 | External wait request, active low |

## Verification
The bench builds the block with its default parameters: 16-bit address and data, a 5-bit wait field and a three-cycle tail. With these values the whole programmed range from 0 to 31 can be driven, including the values below 2 that are clamped and the maximum of 31. Random wait windows of 0 to 12 cycles are placed before, across and after the programmed count. These cover both the case where the count ends the access phase and the case where the wait input ends it. Directed cases cover a wait asserted in cycle 2 with a count of 2, and back-to-back requests with req_i held high.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_TAIL   = 2'd2,
    ST_DONE   = 2'd3
  } smc_state_e;
endpackage

// File: rtl/smc_wait_cnt.sv
module smc_wait_cnt #(
  parameter int unsigned CFG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CFG_W-1:0] limit_i,
  output logic             reached_o
);
  localparam logic [CFG_W-1:0] CntMax = {CFG_W{1'b1}};

  logic [CFG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= CFG_W'(1);
    else if (step_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  // saturates so long nWAIT stretches keep reached asserted
  assign reached_o = (cnt_q >= limit_i);

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && cnt_q == CntMax) |=> (cnt_q == CntMax)); // R5
endmodule

// File: rtl/smc_tail_cnt.sv
module smc_tail_cnt #(
  parameter int unsigned TAIL_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned TW = $clog2(TAIL_CYC + 1);

  logic [TW-1:0] t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t_q <= '0;
    else if (clear_i) t_q <= '0;
    else if (run_i) t_q <= (t_q == TW'(TAIL_CYC - 1)) ? '0 : t_q + 1'b1;
  end

  assign last_o = run_i && (t_q == TW'(TAIL_CYC - 1));

  AST_TAIL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_q < TW'(TAIL_CYC)); // R3
endmodule

// File: rtl/static_mem_seq.sv
module static_mem_seq #(
  parameter int unsigned AW       = 16,
  parameter int unsigned DW       = 16,
  parameter int unsigned CFG_W    = 5,
  parameter int unsigned MIN_WS   = 2,
  parameter int unsigned TAIL_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [CFG_W-1:0] wait_cfg_i,
  output logic             ack_o,
  output logic [DW-1:0]    rdata_o,
  output logic             mem_cs_no,
  output logic             mem_oe_no,
  output logic             mem_we_no,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             mem_wdata_oe_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_wait_ni
);
  import smc_pkg::*;

  localparam logic [CFG_W-1:0] MinWs = CFG_W'(MIN_WS);

  smc_state_e       st_q, st_d;
  logic             we_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic [CFG_W-1:0] limit_q;
  logic             accept, reached, tail_last, busy;

  assign accept = (st_q == ST_IDLE) && req_i;
  assign busy   = (st_q == ST_ACCESS) || (st_q == ST_TAIL);

  smc_wait_cnt #(.CFG_W(CFG_W)) u_wait_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .step_i   (st_q == ST_ACCESS),
    .limit_i  (limit_q),
    .reached_o(reached)
  );

  smc_tail_cnt #(.TAIL_CYC(TAIL_CYC)) u_tail_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(st_q == ST_ACCESS),
    .run_i  (st_q == ST_TAIL),
    .last_o (tail_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_i) st_d = ST_ACCESS;
      ST_ACCESS: if (reached && mem_wait_ni) st_d = ST_TAIL;
      ST_TAIL:   if (tail_last) st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  // request fields are latched once; later input changes are ignored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      limit_q <= MinWs;
    end else if (accept) begin
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      limit_q <= (wait_cfg_i < MinWs) ? MinWs : wait_cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (tail_last && !we_q) rdata_q <= mem_rdata_i;
  end

  assign mem_cs_no      = !busy;
  assign mem_oe_no      = !(busy && !we_q);
  // write strobe releases one cycle before chip select
  assign mem_we_no      = !(busy && we_q && !tail_last);
  assign mem_wdata_oe_o = busy && we_q;
  assign mem_addr_o     = addr_q;
  assign mem_wdata_o    = wdata_q;
  assign ack_o          = (st_q == ST_DONE);
  assign rdata_o        = rdata_q;

  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !mem_cs_no); // R2
  AST_OE_WE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no)); // R2
  AST_LIMIT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_q >= MinWs); // R4
  AST_WAIT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL && $past(st_q) == ST_ACCESS) |-> $past(mem_wait_ni)); // R5
  AST_ACK_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs_no) |-> ack_o); // R7
  AST_ACK_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R9
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_no && $past(!mem_cs_no)) |-> $stable(mem_addr_o)); // R10
endmodule

// File: tb/static_mem_seq_test.sv
module static_mem_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CFG_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_i = 1'b0;
  logic             we_i = 1'b0;
  logic [AW-1:0]    addr_i = '0;
  logic [DW-1:0]    wdata_i = '0;
  logic [CFG_W-1:0] wait_cfg_i = '0;
  logic             ack_o;
  logic [DW-1:0]    rdata_o;
  logic             mem_cs_no, mem_oe_no, mem_we_no, mem_wdata_oe_o;
  logic [AW-1:0]    mem_addr_o;
  logic [DW-1:0]    mem_wdata_o;
  logic [DW-1:0]    mem_rdata_i = '0;
  logic             mem_wait_ni = 1'b1;

  int checks = 0;
  int failures = 0;

  static_mem_seq uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(int cfg, int ws, int wl);
    int k = (cfg < 2) ? 2 : cfg;
    while (wl != 0 && k >= ws && k < ws + wl) k++;
    return k + 3;
  endfunction

  task automatic do_access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int cfg, input int ws, input int wl, input string tag);
    int len;
    logic [DW-1:0] last_rd;
    len = exp_len(cfg, ws, wl);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; wait_cfg_i = CFG_W'(cfg);
    @(negedge clk_i);
    req_i = 1'b0;
    addr_i = ~a; wdata_i = ~d; we_i = ~we; wait_cfg_i = 5'd31; // R10 disturbance
    for (int k = 1; k <= len; k++) begin
      if (k > 1) @(negedge clk_i);
      mem_wait_ni = !(wl != 0 && k >= ws && k < ws + wl);
      mem_rdata_i = DW'($urandom);
      last_rd = mem_rdata_i;
      chk(mem_cs_no == 1'b0, {tag, " R3 R5 cs low"}, mem_cs_no, 0);
      chk(mem_addr_o == a, "R2 R10 address", mem_addr_o, a);
      if (we) begin
        chk(mem_oe_no == 1'b1, "R2 oe idle on write", mem_oe_no, 1);
        chk(mem_we_no == (k == len), "R8 we strobe", mem_we_no, k == len);
        chk(mem_wdata_oe_o && mem_wdata_o == d, "R8 write data", mem_wdata_o, d);
      end else begin
        chk(mem_oe_no == 1'b0 && mem_we_no == 1'b1, "R2 read strobes", {mem_oe_no, mem_we_no}, 1);
        chk(mem_wdata_oe_o == 1'b0, "R2 no drive on read", mem_wdata_oe_o, 0);
      end
      chk(ack_o == 1'b0, "R7 no early ack", ack_o, 0);
    end
    @(negedge clk_i);
    mem_wait_ni = 1'b1;
    chk(mem_cs_no == 1'b1, {tag, " R3 R5 cs released"}, mem_cs_no, 1);
    chk(ack_o == 1'b1, "R7 ack on release", ack_o, 1);
    if (!we) chk(rdata_o == last_rd, "R7 read data", rdata_o, last_rd);
    @(negedge clk_i);
    chk(ack_o == 1'b0, "R9 ack one cycle", ack_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(mem_cs_no && mem_oe_no && mem_we_no, "R1 strobes in reset", {mem_cs_no, mem_oe_no, mem_we_no}, 7);
    chk(!ack_o && !mem_wdata_oe_o, "R1 ack and drive in reset", {ack_o, mem_wdata_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_cs_no && !ack_o, "R1 idle after reset", mem_cs_no, 1);

    do_access(1'b0, 16'h1234, 16'h0, 2, 0, 0, "R3 min");
    do_access(1'b1, 16'h00ff, 16'hbeef, 31, 0, 0, "R3 max");
    do_access(1'b0, 16'h0001, 16'h0, 0, 0, 0, "R4 cfg0");
    do_access(1'b1, 16'h0002, 16'h5a5a, 1, 0, 0, "R4 cfg1");
    do_access(1'b0, 16'h0003, 16'h0, 2, 2, 4, "R5 ws2 wait cycle2");
    do_access(1'b1, 16'h0004, 16'h1111, 6, 1, 5, "R6 early wait");
    do_access(1'b0, 16'h0005, 16'h0, 6, 3, 10, "R5 stretch");

    // R9: request held high, expect two chip-select-high cycles between accesses
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; wait_cfg_i = 5'd2; addr_i = 16'h0abc;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk_i);
      chk(mem_cs_no == (c == 6 || c == 7), "R9 back-to-back cs", mem_cs_no, c == 6 || c == 7);
      chk(ack_o == (c == 6), "R9 back-to-back ack", ack_o, c == 6);
    end
    req_i = 1'b0;
    while (!ack_o) @(negedge clk_i);
    @(negedge clk_i);

    for (int i = 0; i < 60; i++) begin
      do_access(1'($urandom), AW'($urandom), DW'($urandom), int'($urandom_range(0, 31)),
                int'($urandom_range(1, 14)), int'($urandom_range(0, 12)), "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule